// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block models a byte-organized, electrically erasable memory that answers as a target on a two-wire serial bus. SCL and SDA are sampled with a fast system clock through a small synchronizer. From these samples the block finds bus conditions, receives device-select, address and data bytes, and drives acknowledge and read data by pulling SDA low. A host addresses one of up to four devices on the bus with two strap inputs. It sends a two-byte word address and then writes from one to a full page of bytes, or it reads one byte or a stream of bytes from the current or a chosen address.

Written bytes go into a page-sized staging buffer. After the STOP that ends a write, a self-timed programming interval starts. During this interval the staged bytes are copied into the array and the block stays silent on the bus, so a host can poll for completion. A write-protect input cancels the write when STOP arrives. The array depth is set by a word-address width parameter: 15 bits for a 32768-byte part, 14 bits for a 16384-byte part. The default is smaller so that the model elaborates quickly. The page size is 64 bytes.

Top module: `serial_eeprom_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point drops the byte in progress and any data bytes staged but not yet committed, and decoding begins again with a device-select byte.
- R2: The device-select byte is sent MSB first. It is acknowledged only when bits 7:3 equal 10100 and bits 2:1 equal the strap inputs. Bit 0 = 1 selects a read. Any other select byte gets no acknowledge, and the block stays silent until the next START.
- R3: The word address is a high byte followed by a low byte, and each is acknowledged. Address bits at or above ADDR_W are ignored.
- R4: One write may carry 1 to 64 data bytes, each acknowledged. Only the bytes that were sent are changed. The low six address bits wrap from 63 to 0 inside the same page.
- R5: If the write-protect input is high when STOP ends a write, the array is left unchanged and no programming interval starts.
- R6: A write that ends with STOP and wp_i low starts a programming interval of PROG_CYCLES clocks. During this interval the block acknowledges no byte, including its own device-select byte.
- R7: A read returns the byte at the current address. The address then advances through the whole array and wraps from the last address to 0. A host ACK (SDA low) asks for the next byte, and a host NACK ends the read. A random read is a write select with the address, then a repeated START and a read select.
- R8: Incoming bits are sampled on the SCL rising edge. sda_pull_o changes only while SCL is low, and it is low after reset. When sda_pull_o = 1, SDA is pulled low. Otherwise SDA is released, and it is never driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 2 | Device address straps, matched to select bits 2:1 |
| wp_i | input | 1 | Write protect, high blocks writes |

## Verification
The hardest cases to reach are an interrupted transfer and the boundaries of the programming interval. For the interrupted transfer, the bench sends half of a low address byte and then issues a repeated START. It also stages a data byte and then restarts before any STOP. In each case it shows through later reads and immediate polls that neither the address pointer nor the array moved. For the programming interval, the bench polls right after STOP to see the missing acknowledge, and again after the interval ends. It also repeats the write with protect set and expects an immediate acknowledge. Page wrap and array wrap are reached by writing close to the last offset of a page and to the last address of the array.

// File: rtl/eeprom_pkg.sv
// Shared types for the serial EEPROM target.
// Assumes: used only by the eeprom_* modules and their checker.
package eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV, K_AHI, K_ALO, K_DATA
    } byte_kind_e;

    localparam logic [4:0] DEV_PREFIX = 5'b10100;
endpackage

// File: rtl/eeprom_line_sense.sv
// Synchronizes SCL/SDA into the clk domain and flags SCL edges and
// START/STOP conditions. Assumes SCL is at least several clk periods long.
module eeprom_line_sense #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC-1:0] scl_sy, sda_sy;
    logic            scl_p, sda_p, scl_s;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC-2:0], sda_i};
            scl_p  <= scl_sy[SYNC-1];
            sda_p  <= sda_sy[SYNC-1];
        end
    end

    // Edge and bus-condition decode from the synchronized samples.
    always_comb begin
        scl_s     = scl_sy[SYNC-1];
        sda_s     = sda_sy[SYNC-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/eeprom_byte_array.sv
// Byte storage: one synchronous write port and one combinational read port.
// Assumes writes and reads are never needed in the same cycle at one address.
module eeprom_byte_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] mem [DEPTH];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the byte at the current pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_page_commit.sv
// Page staging buffer with per-byte valid mask and the programming timer.
// During the busy interval it copies the valid staged bytes into the array,
// one offset per clock. Assumes PROG_CYCLES > page size.
module eeprom_page_commit #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 6,
    parameter int PROG_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [PAGE_W-1:0]        ld_off,
    input  logic [7:0]               ld_data,
    input  logic                     clr,
    input  logic                     go,
    input  logic [ADDR_W-PAGE_W-1:0] go_page,
    output logic                     busy,
    output logic                     has_data,
    output logic                     we,
    output logic [ADDR_W-1:0]        waddr,
    output logic [7:0]               wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TMR_W      = $clog2(PROG_CYCLES);
    localparam logic [TMR_W-1:0] T_PAGE = TMR_W'(PAGE_BYTES);
    localparam logic [TMR_W-1:0] T_LAST = TMR_W'(PROG_CYCLES - 1);

    logic [7:0]               stage_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    mask_q;
    logic [TMR_W-1:0]         tmr_q;
    logic                     busy_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;

    // Staged data bytes, no reset needed.
    always_ff @(posedge clk) begin
        if (ld_en) stage_q[ld_off] <= ld_data;
    end

    // Valid mask, busy flag and programming timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            busy_q <= 1'b0;
            tmr_q  <= '0;
            page_q <= '0;
        end else if (busy_q) begin
            if (tmr_q == T_LAST) begin
                busy_q <= 1'b0;
                mask_q <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end else if (go) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
            page_q <= go_page;
        end else if (clr) begin
            mask_q <= '0;
        end else if (ld_en) begin
            mask_q[ld_off] <= 1'b1;
        end
    end

    // Array write port driven by the commit walk over the page offsets.
    always_comb begin
        busy     = busy_q;
        has_data = |mask_q;
        we       = busy_q && (tmr_q < T_PAGE) && mask_q[tmr_q[PAGE_W-1:0]];
        waddr    = {page_q, tmr_q[PAGE_W-1:0]};
        wdata    = stage_q[tmr_q[PAGE_W-1:0]];
    end
endmodule

// File: rtl/serial_eeprom_target.sv
// Two-wire serial EEPROM target: byte-level bus engine, address pointer,
// and glue to the staging buffer and array. Assumes the host changes SDA
// only while SCL is low, except for START and STOP conditions.
module serial_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 6,
    parameter int PROG_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    localparam int HI_W = ADDR_W - 8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, has_data, arr_we, ld_en, clr, go;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata, rdata;

    bus_st_e           st_q;
    byte_kind_e        kind_q;
    logic [3:0]        cnt_q;
    logic [7:0]        sh_q, tx_q;
    logic [HI_W-1:0]   ahi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              go_tx_q, mack_ok_q, pull_q;

    eeprom_line_sense #(.SYNC(2)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_page_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
                         .PROG_CYCLES(PROG_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
        .ld_off(ptr_q[PAGE_W-1:0]), .ld_data(sh_q), .clr(clr), .go(go),
        .go_page(ptr_q[ADDR_W-1:PAGE_W]), .busy(busy), .has_data(has_data),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata)
    );

    eeprom_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(ptr_q), .rdata(rdata)
    );

    // Staging-buffer controls: load data bytes, commit or discard at STOP.
    always_comb begin
        ld_en = (st_q == ST_RX) && scl_fall && (cnt_q == 4'd8) && (kind_q == K_DATA);
        go    = stop_det && has_data && !busy && !wp_i;
        clr   = (stop_det && has_data && !busy && wp_i) || (start_det && !busy);
    end

    // Bus engine: receive bytes, acknowledge, transmit read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            kind_q    <= K_DEV;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            ahi_q     <= '0;
            ptr_q     <= '0;
            go_tx_q   <= 1'b0;
            mack_ok_q <= 1'b0;
            pull_q    <= 1'b0;
        end else if (start_det) begin
            st_q   <= ST_RX;
            kind_q <= K_DEV;
            cnt_q  <= '0;
            pull_q <= 1'b0;
        end else if (stop_det) begin
            st_q   <= ST_IDLE;
            pull_q <= 1'b0;
        end else begin
            case (st_q)
                ST_RX: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[6:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        cnt_q  <= '0;
                        st_q   <= ST_ACK;
                        pull_q <= 1'b1;
                        case (kind_q)
                            K_DEV: begin
                                if (sh_q[7:3] == DEV_PREFIX && sh_q[2:1] == strap_i && !busy) begin
                                    go_tx_q <= sh_q[0];
                                    kind_q  <= K_AHI;
                                end else begin
                                    st_q   <= ST_SKIP;
                                    pull_q <= 1'b0;
                                end
                            end
                            K_AHI: begin
                                ahi_q  <= sh_q[HI_W-1:0];
                                kind_q <= K_ALO;
                            end
                            K_ALO: begin
                                ptr_q  <= {ahi_q, sh_q};
                                kind_q <= K_DATA;
                            end
                            default: ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (go_tx_q) begin
                            go_tx_q <= 1'b0;
                            tx_q    <= rdata;
                            pull_q  <= ~rdata[7];
                            cnt_q   <= 4'd1;
                            st_q    <= ST_TX;
                        end else begin
                            pull_q <= 1'b0;
                            st_q   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == 4'd8) begin
                            pull_q    <= 1'b0;
                            st_q      <= ST_MACK;
                            ptr_q     <= ptr_q + 1'b1;
                            mack_ok_q <= 1'b0;
                        end else begin
                            pull_q <= ~tx_q[6];
                            tx_q   <= {tx_q[6:0], 1'b0};
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) st_q <= ST_SKIP;
                        else       mack_ok_q <= 1'b1;
                    end else if (scl_fall && mack_ok_q) begin
                        tx_q   <= rdata;
                        pull_q <= ~rdata[7];
                        cnt_q  <= 4'd1;
                        st_q   <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull_q;
endmodule

// File: rtl/eeprom_checks.sv
// Protocol checker for serial_eeprom_target, bound into every instance.
// Assumes the host keeps SCL phases several clk periods long.
module eeprom_checks
    import eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       wp_i,
    input logic       sda_pull_o,
    input logic       busy,
    input logic       start_det,
    input logic       stop_det,
    input bus_st_e    st_q,
    input logic [3:0] cnt_q
);
    // R8: the pull output only moves while SCL is low.
    p_pull_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    // R5: a programming interval never begins with protect high.
    p_wp_no_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    // R6: programming begins only from a STOP condition.
    p_prog_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R6: nothing is acknowledged while programming.
    p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R1: START restarts byte reception from bit zero.
    p_start_resets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st_q == ST_RX && cnt_q == 4'd0));
endmodule

bind serial_eeprom_target eeprom_checks u_checks (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i),
    .sda_pull_o(sda_pull_o), .busy(busy), .start_det(start_det),
    .stop_det(stop_det), .st_q(st_q), .cnt_q(cnt_q)
);

// File: tb/test_serial_eeprom_target.sv
// Scoreboard bench: host tasks push expected SDA bits, a monitor pops and
// compares them at each sampled SCL rising edge.
module test_serial_eeprom_target;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PROG   = 800;
    localparam int Q      = 10;
    localparam logic [1:0] STRAP = 2'b01;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hpull = 1'b0, wp = 1'b0;
    logic mon_en = 1'b0, done = 1'b0;
    logic sda_pull;
    logic sda_line;
    int   n_tests = 0, n_fail = 0;
    logic  exp_q [$];
    string tag_q [$];
    logic [7:0] model [DEPTH];

    assign sda_line = ~(hpull | sda_pull);

    always #4 clk = ~clk;

    serial_eeprom_target #(.ADDR_W(ADDR_W), .PAGE_W(6), .PROG_CYCLES(PROG)) i_serial_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(STRAP), .wp_i(wp)
    );

    // Monitor: compare the bus against the next expected bit.
    always @(posedge scl) begin
        if (mon_en) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8: unexpected sample, actual %b expected none", sda_line);
            end else begin
                logic  v;
                string t;
                v = exp_q.pop_front();
                t = tag_q.pop_front();
                if (sda_line !== v) begin
                    n_fail++;
                    $display("FAIL %s: sda actual %b expected %b", t, sda_line, v);
                end
            end
        end
    end

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        hpull = ~b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    endtask

    task automatic bus_start();
        hpull = 1'b0; q(); scl = 1'b1; q(); hpull = 1'b1; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        hpull = 1'b1; q(); scl = 1'b1; q(); hpull = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string tag);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        exp_q.push_back(~ack); tag_q.push_back(tag);
        hpull = 1'b0; mon_en = 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; mon_en = 1'b0; q();
    endtask

    task automatic read_byte(input logic [7:0] e, input logic last, input string tag);
        for (int i = 7; i >= 0; i--) begin exp_q.push_back(e[i]); tag_q.push_back(tag); end
        hpull = 1'b0; mon_en = 1'b1;
        for (int i = 0; i < 8; i++) begin q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); end
        mon_en = 1'b0;
        put_bit(last);
    endtask

    function automatic logic [7:0] dsel(input logic [1:0] s, input logic rw);
        return {5'b10100, s, rw};
    endfunction

    task automatic poll(input logic ack, input string tag);
        bus_start(); send_byte(dsel(STRAP, 1'b0), ack, tag); bus_stop();
    endtask

    task automatic write_page(input logic [15:0] a, input logic [7:0] d [4], input int n, input string tag);
        int base, off;
        bus_start();
        send_byte(dsel(STRAP, 1'b0), 1'b1, tag);
        send_byte(a[15:8], 1'b1, tag);
        send_byte(a[7:0], 1'b1, tag);
        for (int i = 0; i < n; i++) send_byte(d[i], 1'b1, tag);
        bus_stop();
        base = int'(a) & (DEPTH - 1) & ~63;
        off  = int'(a) & 63;
        if (!wp) for (int i = 0; i < n; i++) model[base | ((off + i) & 63)] = d[i];
    endtask

    task automatic wait_prog();
        repeat (PROG + 100) @(negedge clk);
    endtask

    task automatic read_at(input int a, input int n, input string tag);
        bus_start();
        send_byte(dsel(STRAP, 1'b0), 1'b1, tag);
        send_byte(8'(a >> 8), 1'b1, tag);
        send_byte(8'(a), 1'b1, tag);
        bus_start();
        send_byte(dsel(STRAP, 1'b1), 1'b1, tag);
        for (int i = 0; i < n; i++) read_byte(model[(a + i) & (DEPTH - 1)], i == n - 1, tag);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        n_tests++;
        if (sda_pull !== 1'b0) begin
            n_fail++; $display("FAIL R8: reset pull actual %b expected 0", sda_pull);
        end

        // R2: select matching
        bus_start(); send_byte(dsel(2'b10, 1'b0), 1'b0, "R2 wrong strap"); bus_stop();
        bus_start(); send_byte(8'b1011_0010, 1'b0, "R2 wrong prefix"); bus_stop();
        poll(1'b1, "R2 matching select");

        // R4/R6: partial page write, busy poll, readback
        write_page(16'h0103, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, "R4 write");
        poll(1'b0, "R6 busy nack");
        wait_prog();
        poll(1'b1, "R6 ack after interval");
        read_at(16'h0103, 3, "R4 readback");

        // R4: single byte leaves neighbours intact
        write_page(16'h0104, '{8'h44, 8'h00, 8'h00, 8'h00}, 1, "R4 partial");
        wait_prog();
        read_at(16'h0103, 3, "R4 neighbours kept");

        // R4: wrap inside the page
        write_page(16'h0180, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, "R4 next page");
        wait_prog();
        write_page(16'h017E, '{8'h61, 8'h62, 8'h63, 8'h64}, 4, "R4 wrap write");
        wait_prog();
        read_at(16'h017E, 2, "R4 page tail");
        read_at(16'h0140, 2, "R4 page head wrapped");
        read_at(16'h0180, 1, "R4 next page untouched");

        // R5: protected write changes nothing and starts no interval
        wp = 1'b1;
        write_page(16'h0103, '{8'hEE, 8'h00, 8'h00, 8'h00}, 1, "R5 protected write");
        poll(1'b1, "R5 no busy interval");
        wp = 1'b0;
        read_at(16'h0103, 1, "R5 array unchanged");

        // R3: high address bits ignored
        write_page(16'h7020, '{8'h9C, 8'h00, 8'h00, 8'h00}, 1, "R3 write high bits");
        wait_prog();
        read_at(16'h0020, 1, "R3 aliased read");

        // R7: array wrap and current-address read
        write_page(16'h07FF, '{8'hA1, 8'h00, 8'h00, 8'h00}, 1, "R7 last address");
        wait_prog();
        write_page(16'h0000, '{8'hB2, 8'hC3, 8'hD4, 8'h00}, 3, "R7 first address");
        wait_prog();
        read_at(16'h07FF, 2, "R7 sequential wrap");
        bus_start();
        send_byte(dsel(STRAP, 1'b1), 1'b1, "R7 current read");
        read_byte(model[1], 1'b1, "R7 current read");
        bus_stop();

        // R1: abort inside the low address byte, pointer stays at 0x002
        bus_start();
        send_byte(dsel(STRAP, 1'b0), 1'b1, "R1 abort addr");
        send_byte(8'h01, 1'b1, "R1 abort addr");
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(dsel(STRAP, 1'b1), 1'b1, "R1 restart select");
        read_byte(model[2], 1'b1, "R1 pointer unchanged");
        bus_stop();

        // R1: staged data dropped by repeated START
        bus_start();
        send_byte(dsel(STRAP, 1'b0), 1'b1, "R1 abort data");
        send_byte(8'h01, 1'b1, "R1 abort data");
        send_byte(8'h03, 1'b1, "R1 abort data");
        send_byte(8'h77, 1'b1, "R1 abort data");
        bus_start();
        send_byte(dsel(STRAP, 1'b0), 1'b1, "R1 abort data");
        bus_stop();
        poll(1'b1, "R1 no interval after abort");
        read_at(16'h0103, 1, "R1 data not written");

        repeat (20) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R8: pending samples actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule